// File: doc/BRIEF.md
# Single-Phase Complementary Gate Driver with Diode Emulation

This block drives the two switches of one phase of a peak-current-mode power converter. A rising edge on the phase PWM input opens a conduction interval for the main switch. The interval closes when the digital peak-current trip asserts. The synchronous-rectifier drive is the complement of the main drive, with a programmable dead band on each transition. It is also ANDed with a zero-current detect input. Once the inductor current reaches zero in discontinuous conduction, the rectifier stays off for the rest of the switching period.

Every input is a plain level signal sampled on the rising clock edge. Neither side has a handshake or back-pressure, because the pins are control pins and carry no data stream. The dead band is given as a count of clock cycles. At a 100 MHz clock, a setting of 11 covers an overlap of about 110 ns. A phase controller instantiates one copy per phase and feeds each copy its own phase-shifted PWM.

Top module: `cgd_phase_driver`

## Requirements
- R1: A rising edge on `pwm_in` that is sampled at clock edge k, with `peak_trip` low, raises `main_drv` after edge k+1. This holds when `sync_drv` has already been low for at least `dead_cyc` cycles.
- R2: `peak_trip` sampled high at edge t makes `main_drv` low after edge t+1. `main_drv` then stays low until the next `pwm_in` rising edge.
- R3: If `peak_trip` is high at the edge where a `pwm_in` rising edge is sampled, `main_drv` stays low for that whole period, and `sync_drv` also stays low for that period.
- R4: `main_drv` and `sync_drv` are never high in the same cycle.
- R5: `main_drv` rises only after `sync_drv` has been low for `dead_cyc` full cycles. When the main interval starts while the rectifier is on, `sync_drv` falls after edge k+1, and `main_drv` rises `dead_cyc` cycles later.
- R6: After `main_drv` falls, `sync_drv` rises exactly `dead_cyc` cycles later, provided `zc_ok` is high.
- R7: `zc_ok` low at an edge while the main interval is closed drives `sync_drv` low after that edge. `sync_drv` then stays low until the next `pwm_in` rising edge, even if `zc_ok` returns high.
- R8: `zc_ok` going low while the main interval is open has no effect, and the rectifier still turns on after the trip.
- R9: After reset, both outputs are low. `sync_drv` stays low until a main interval has taken place.
- R10: `en` low forces both outputs low in the same cycle and clears the period state. After `en` returns, both outputs stay low until the next `pwm_in` rising edge.
- R11: With `dead_cyc` = 0, one output falls and the other rises on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable. When low, both outputs are low at once |
| pwm_in | input | 1 | Phase PWM. Its rising edge opens the main interval |
| peak_trip | input | 1 | Peak-current comparator output. High closes the interval |
| zc_ok | input | 1 | Zero-current detect. High while current still flows, low at zero |
| dead_cyc | input | DEAD_W | Dead band in clock cycles |
| main_drv | output | 1 | Main switch drive |
| sync_drv | output | 1 | Synchronous rectifier drive |

## Verification
The bound checker verifies three behaviours on every cycle: that the two drives are never both high, that each rising edge follows at least the programmed number of low cycles on the opposite drive, and that a disable or a peak trip clears the drives on time. It also checks that a zero-current indication while the main interval is closed turns the rectifier off on the next edge. The bench's scenarios cover the other behaviours. These are the exact latencies from the PWM edge and the trip, and a dead band of exactly the set count rather than at least it. They also include the lock that holds the rectifier off after the detect recovers, the skipped period when the trip is present at the start, and the recovery after a disable. The bench sweeps these scenarios over several dead-band settings, including zero.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  // width of the dead-band count; 8 bits cover 2.55 us at 100 MHz
  localparam int unsigned DEAD_W_DEF = 8;

  // requests handed from the period controller to the two dead-band gates
  typedef struct packed {
    logic main_on;
    logic sync_on;
  } drive_req_t;
endpackage

// File: rtl/cgd_period_ctrl.sv
module cgd_period_ctrl
  import cgd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       pwm_in,
  input  logic       peak_trip,
  input  logic       zc_ok,
  output drive_req_t req
);
  logic pwm_q;
  logic start;
  logic on_q;     // main conduction interval open
  logic zlock_q;  // rectifier held off for the rest of the period

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_in;
  end

  assign start = pwm_in & ~pwm_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      on_q    <= 1'b0;
      zlock_q <= 1'b1;
    end else if (start) begin
      // a trip already present skips the period and keeps the rectifier off
      on_q    <= ~peak_trip;
      zlock_q <= peak_trip;
    end else begin
      if (peak_trip)        on_q    <= 1'b0;
      if (!on_q && !zc_ok)  zlock_q <= 1'b1;
    end
  end

  always_comb begin
    req.main_on = on_q;
    req.sync_on = ~on_q & ~zlock_q & zc_ok;
  end
endmodule

// File: rtl/cgd_dead_gate.sv
module cgd_dead_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         req,
  input  logic         other_on,
  input  logic [W-1:0] dead,
  output logic         drv_q
);
  localparam logic [W-1:0] RUN_MAX = {W{1'b1}};

  logic [W-1:0] run_q;    // cycles the opposite drive has been low, saturating
  logic [W:0]   low_len;  // including the current cycle
  logic         clear;

  always_ff @(posedge clk) begin
    if (rst || other_on)     run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + W'(1);
  end

  always_comb begin
    low_len = other_on ? '0 : ({1'b0, run_q} + (W+1)'(1));
    clear   = low_len >= {1'b0, dead};
  end

  always_ff @(posedge clk) begin
    if (rst || !en) drv_q <= 1'b0;
    else            drv_q <= req & clear;
  end
endmodule

// File: rtl/cgd_phase_driver.sv
module cgd_phase_driver
  import cgd_pkg::*;
#(
  parameter int unsigned DEAD_W = DEAD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pwm_in,
  input  logic              peak_trip,
  input  logic              zc_ok,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic              main_drv,
  output logic              sync_drv
);
  drive_req_t req;
  logic [1:0] drv_q;
  logic [1:0] drv_out;
  logic [1:0] req_v;

  cgd_period_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .pwm_in    (pwm_in),
    .peak_trip (peak_trip),
    .zc_ok     (zc_ok),
    .req       (req)
  );

  assign req_v = {req.sync_on, req.main_on};

  // index 0 = main switch, index 1 = synchronous rectifier; each waits on the other
  for (genvar g = 0; g < 2; g++) begin : g_gate
    cgd_dead_gate #(.W(DEAD_W)) u_gate (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .req      (req_v[g]),
      .other_on (drv_out[1-g]),
      .dead     (dead_cyc),
      .drv_q    (drv_q[g])
    );
  end

  assign drv_out  = drv_q & {2{en}};
  assign main_drv = drv_out[0];
  assign sync_drv = drv_out[1];
endmodule

// File: rtl/cgd_phase_driver_chk.sv
module cgd_phase_driver_chk #(
  parameter int unsigned DEAD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              peak_trip,
  input logic              zc_ok,
  input logic [DEAD_W-1:0] dead_cyc,
  input logic              main_drv,
  input logic              sync_drv
);
  localparam logic [DEAD_W:0] SAT = {(DEAD_W+1){1'b1}};
  logic [DEAD_W:0] m_low;
  logic [DEAD_W:0] s_low;

  always_ff @(posedge clk) begin
    if (rst || main_drv) m_low <= '0;
    else if (m_low != SAT) m_low <= m_low + (DEAD_W+1)'(1);
    if (rst || sync_drv) s_low <= '0;
    else if (s_low != SAT) s_low <= s_low + (DEAD_W+1)'(1);
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(main_drv && sync_drv));

  // R10
  disable_low_chk: assert property (@(posedge clk) disable iff (rst) !en |-> (!main_drv && !sync_drv));

  // R5
  main_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(main_drv) |-> (s_low >= {1'b0, dead_cyc}));

  // R6
  sync_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_drv) |-> (m_low >= {1'b0, dead_cyc}));

  // R2
  trip_off_chk: assert property (@(posedge clk) disable iff (rst) peak_trip |-> ##2 !main_drv);

  // R7
  zero_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (!main_drv && !zc_ok) |=> !sync_drv);
endmodule

bind cgd_phase_driver cgd_phase_driver_chk #(.DEAD_W(DEAD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .peak_trip (peak_trip),
  .zc_ok     (zc_ok),
  .dead_cyc  (dead_cyc),
  .main_drv  (main_drv),
  .sync_drv  (sync_drv)
);

// File: tb/sim_cgd_phase_driver.sv
`timescale 1ns/1ps
module sim_cgd_phase_driver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       pwm_in = 1'b0;
  logic       peak_trip = 1'b0;
  logic       zc_ok = 1'b1;
  logic [7:0] dead_cyc = 8'd0;
  logic       main_drv;
  logic       sync_drv;

  int n = 0;
  int checks = 0;
  int fails = 0;
  int overlap = 0;

  always #2.5 clk = ~clk;

  cgd_phase_driver #(.DEAD_W(8)) u0 (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm_in), .peak_trip(peak_trip),
    .zc_ok(zc_ok), .dead_cyc(dead_cyc), .main_drv(main_drv), .sync_drv(sync_drv)
  );

  always @(negedge clk) if (!rst && main_drv && sync_drv) overlap++;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cyc();
    @(negedge clk);
    n++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sel 0 = main_drv, 1 = sync_drv; returns the sample index where the value appears
  task automatic await_sig(input int sel, input logic val, output int idx);
    idx = -1000;
    for (int k = 0; k < 80; k++) begin
      if (((sel == 0) ? main_drv : sync_drv) === val) begin
        idx = n;
        break;
      end
      cyc();
    end
  endtask

  task automatic lock_idle();
    zc_ok = 1'b0; cyc(); zc_ok = 1'b1;
    repeat (20) cyc();
  endtask

  task automatic run_dead(input int d);
    int a, r, b, f, s, c, g, h, e, s2, z, hits;
    dead_cyc = 8'(d);
    lock_idle();
    // R1: start from a locked, idle rectifier
    a = n; pwm_in = 1'b1; cyc(); pwm_in = 1'b0;
    await_sig(0, 1'b1, r);
    chk($sformatf("R1 main rise latency dead=%0d", d), r - a, 2);
    // R8: zero-current indication inside the on interval is ignored
    cyc(); zc_ok = 1'b0; cyc(); zc_ok = 1'b1; repeat (2) cyc();
    b = n; peak_trip = 1'b1; cyc(); peak_trip = 1'b0;
    await_sig(0, 1'b0, f);
    chk($sformatf("R2 main fall after trip dead=%0d", d), f - b, 2);
    await_sig(1, 1'b1, s);
    chk($sformatf("R6 R8 sync rise after trip dead=%0d", d), s - b, 2 + d);
    // R5: next period starts while the rectifier is on
    repeat (4) cyc();
    c = n; pwm_in = 1'b1; cyc(); pwm_in = 1'b0;
    await_sig(1, 1'b0, g);
    chk($sformatf("R5 sync fall after start dead=%0d", d), g - c, 2);
    await_sig(0, 1'b1, h);
    chk($sformatf("R5 main rise after dead band dead=%0d", d), h - c, 2 + d);
    if (d == 0) chk("R11 same-edge handover", h - g, 0);
    repeat (3) cyc();
    e = n; peak_trip = 1'b1; cyc(); peak_trip = 1'b0;
    await_sig(1, 1'b1, s2);
    chk($sformatf("R6 second sync rise dead=%0d", d), s2 - e, 2 + d);
    // R7: zero current cuts the rectifier and the cut is held
    repeat (2) cyc();
    z = n; zc_ok = 1'b0; cyc();
    chk($sformatf("R7 sync cut by zero current dead=%0d", d), int'(sync_drv), 0);
    chk("R7 cut latency", n - z, 1);
    zc_ok = 1'b1; hits = 0;
    for (int k = 0; k < 8; k++) begin cyc(); if (sync_drv) hits++; end
    chk($sformatf("R7 cut held after detect recovers dead=%0d", d), hits, 0);
    // R3: trip present at the start skips the period
    pwm_in = 1'b1; peak_trip = 1'b1; cyc(); pwm_in = 1'b0; peak_trip = 1'b0;
    hits = 0;
    for (int k = 0; k < 10 + d; k++) begin cyc(); if (main_drv || sync_drv) hits++; end
    chk($sformatf("R3 skipped period dead=%0d", d), hits, 0);
  endtask

  initial begin
    int r, a, hits;
    repeat (3) cyc();
    rst = 1'b0;
    repeat (6) cyc();
    // R9
    chk("R9 main low after reset", int'(main_drv), 0);
    chk("R9 sync held off before first interval", int'(sync_drv), 0);

    for (int d = 0; d < 6; d++) run_dead(d);
    run_dead(11);

    // R10: disable mid-interval
    dead_cyc = 8'd2;
    lock_idle();
    pwm_in = 1'b1; cyc(); pwm_in = 1'b0;
    await_sig(0, 1'b1, r);
    cyc();
    en = 1'b0; #1;
    chk("R10 main forced low at once", int'(main_drv), 0);
    hits = 0;
    peak_trip = 1'b1; cyc(); peak_trip = 1'b0;
    for (int k = 0; k < 5; k++) begin cyc(); if (main_drv || sync_drv) hits++; end
    chk("R10 both low while disabled", hits, 0);
    en = 1'b1; hits = 0;
    for (int k = 0; k < 8; k++) begin cyc(); if (main_drv || sync_drv) hits++; end
    chk("R10 idle after re-enable", hits, 0);
    a = n; pwm_in = 1'b1; cyc(); pwm_in = 1'b0;
    await_sig(0, 1'b1, r);
    chk("R10 new start after re-enable", r - a, 2);

    // R4
    chk("R4 overlap cycles", overlap, 0);
    report();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    report();
    $finish;
  end
endmodule